// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block is the read half of a bus target that sits between a 32-bit host bus and a slower local space. The local space is 16 bits wide and holds a memory and a bank of registers. A host read that must reach the local side is never held on the bus. The first attempt is answered with Retry, and the request is stored in a single delayed-read slot. The block then fetches the data with one or two 16-bit local accesses. Every later attempt with identical request fields is answered with Retry until the data is ready. The attempt that finds the data ready is answered with disconnect-with-data, and that answer frees the slot.

Some reads never use the slot. These are the bridge's own status window, reads that can only return zero, and reads the block rejects with Target-Abort. They are all answered on the first attempt. A request is stored only while the posted-write FIFO is empty. If the data is ready but nobody collects it, a discard timer frees the slot after a fixed number of host clocks.

Top module: `drr_ctrl`

## Requirements
- R1: A read that needs the local side is answered with Retry on its first attempt and is stored in the slot. Identical attempts made while the fetch is still running also get Retry. The first identical attempt after the data is ready gets disconnect-with-data with the fetched data. That attempt frees the slot, so the next identical attempt is treated as a new request and gets Retry.
- R2: While `wfifo_empty` is 0, a read that needs the local side gets Retry. It is not stored, and no local access starts.
- R3: A read in region 1 at byte offsets 0x800 to 0x81F is answered on its first attempt with disconnect-with-data. This holds whatever the slot state and the FIFO level. At offset 0x800, bit 30 is the write-FIFO-not-empty flag, bit 1 is data-ready and bit 0 is slot-occupied. All other bits, and all other offsets in the window, read as 0.
- R4: A retry matches the stored request only when region, address, command and byte enables are all equal. A read that does not match while the slot is occupied gets Retry and does not disturb the stored request.
- R5: Region 0 (memory) accepts any byte-enable pattern (bit 0 enables the lowest byte).
  - A 16-bit half with at least one byte enabled is fetched and returned whole.
  - A half with no byte enabled returns zero.
  - The local word address is the host byte address shifted right by 1, with bit 0 cleared for the low half and set for the high half.
  - When both halves are needed, the low half is fetched first.
- R6: In region 1, a read gets Target-Abort in two cases. The first is an address at offset 0x000 to 0x0FF (the local register window) with exactly one byte enabled in either 16-bit half. The second is an address outside both the register window and the status window.
- R7: A read is answered on its first attempt with disconnect-with-data and all-zero data, and no local access, in two cases. The first is a read with no byte enable in either region. The second is a read in the register window with neither of byte enables 0 and 1 set.
- R8: A register-window read with byte enables 0 and 1 both set makes one local access with `loc_reg_sel` = 1 and local address = host address bits 7:2. It returns the register in data bits 15:0 and zero in bits 31:16.
- R9: If ready data is not collected, the slot is freed DISCARD_LIMIT host clocks after it became ready. A matching attempt that arrives in the very clock where the slot would be discarded is still served.
- R10: `loc_req` stays high with a stable `loc_addr` until `loc_ack` is sampled high, for any number of wait states.
- R11: The answer appears in the clock after the attempt, with `hst_done` = 1 and `hst_term` = 1 for Retry, 2 for disconnect-with-data and 3 for Target-Abort. `hst_rdata` is 0 except with code 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host read attempt in this cycle |
| hst_region | input | 1 | 0 = memory region, 1 = register/status region |
| hst_addr | input | ADDR_W | Host byte address within the region |
| hst_cmd | input | 4 | Host read command code, kept for matching |
| hst_be | input | 4 | Byte enables, active high |
| wfifo_empty | input | 1 | Posted-write FIFO is empty |
| hst_done | output | 1 | Answer valid for the previous attempt |
| hst_term | output | 2 | Termination code |
| hst_rdata | output | 32 | Read data |
| loc_req | output | 1 | Local read request |
| loc_reg_sel | output | 1 | Local access targets registers (1) or memory (0) |
| loc_addr | output | ADDR_W-1 | Local 16-bit word address |
| loc_ack | input | 1 | Local access complete, data valid |
| loc_rdata | input | 16 | Local read data |

## Verification
The discard timer expiring and a matching retry collecting the data can fall in the same clock. The bench polls the status window every cycle to find the exact clock in which data became ready. It then places the collecting attempt on the last clock before expiry, and expects disconnect-with-data with the correct data. A second run places the attempt one clock later and expects Retry, because the slot has gone and the attempt starts a new request. Status reads issued in the middle of a fetch show that the direct path answers while the slot is busy, without changing the slot.

// File: rtl/drr_ctrl.sv
module drr_ctrl #(
  parameter int ADDR_W        = 16,
  parameter int DISCARD_LIMIT = 1024,
  localparam int LA_W  = ADDR_W - 1,
  localparam int CNT_W = $clog2(DISCARD_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_req,
  input  logic              hst_region,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [3:0]        hst_cmd,
  input  logic [3:0]        hst_be,
  input  logic              wfifo_empty,
  output logic              hst_done,
  output logic [1:0]        hst_term,
  output logic [31:0]       hst_rdata,
  output logic              loc_req,
  output logic              loc_reg_sel,
  output logic [LA_W-1:0]   loc_addr,
  input  logic              loc_ack,
  input  logic [15:0]       loc_rdata
);

  localparam logic [1:0] T_NONE = 2'd0, T_RETRY = 2'd1, T_DATA = 2'd2, T_ABORT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_READY} slot_t;
  slot_t st;

  logic              s_region, s_need_hi, s_cur_hi;
  logic [ADDR_W-1:0] s_addr;
  logic [3:0]        s_cmd, s_be;
  logic [31:0]       s_data;
  logic [CNT_W-1:0]  age;

  wire in_stat  = hst_region && hst_addr >= ADDR_W'(12'h800) && hst_addr <= ADDR_W'(12'h81F);
  wire in_lreg  = hst_region && hst_addr < ADDR_W'(12'h100);
  wire lo_one   = ^hst_be[1:0];
  wire hi_one   = ^hst_be[3:2];
  wire is_abort = hst_region && !in_stat && (!in_lreg || lo_one || hi_one);
  wire is_zero  = !in_stat && !is_abort && (hst_be == 4'h0 || (in_lreg && hst_be[1:0] == 2'b00));
  wire dly      = !in_stat && !is_abort && !is_zero;
  wire need_lo  = in_lreg ? 1'b1 : |hst_be[1:0];
  wire need_hi  = in_lreg ? 1'b0 : |hst_be[3:2];
  wire hit      = s_region == hst_region && s_addr == hst_addr && s_cmd == hst_cmd && s_be == hst_be;
  wire collect  = hst_req && dly && hit && st == S_READY;
  wire expire   = st == S_READY && age == CNT_W'(DISCARD_LIMIT - 1);

  wire [31:0] stat_word = (hst_addr[4:2] == 3'd0)
                        ? {1'b0, !wfifo_empty, 28'b0, st == S_READY, st != S_IDLE} : 32'h0;

  assign loc_req     = st == S_FETCH;
  assign loc_reg_sel = s_region;
  assign loc_addr    = s_region ? LA_W'(s_addr[7:2]) : {s_addr[ADDR_W-1:2], s_cur_hi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hst_done  <= 1'b0;
      hst_term  <= T_NONE;
      hst_rdata <= 32'h0;
    end else begin
      hst_done  <= hst_req;
      hst_rdata <= 32'h0;
      if (!hst_req)      hst_term <= T_NONE;
      else if (in_stat)  begin hst_term <= T_DATA; hst_rdata <= stat_word; end
      else if (is_abort) hst_term <= T_ABORT;
      else if (is_zero)  hst_term <= T_DATA;
      else if (collect)  begin hst_term <= T_DATA; hst_rdata <= s_data; end
      else               hst_term <= T_RETRY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      s_region <= 1'b0; s_addr <= '0; s_cmd <= '0; s_be <= '0;
      s_need_hi <= 1'b0; s_cur_hi <= 1'b0; s_data <= '0; age <= '0;
    end else begin
      case (st)
        S_IDLE: if (hst_req && dly && wfifo_empty) begin
          s_region  <= hst_region;
          s_addr    <= hst_addr;
          s_cmd     <= hst_cmd;
          s_be      <= hst_be;
          s_need_hi <= need_hi;
          s_cur_hi  <= !need_lo;
          s_data    <= '0;
          st        <= S_FETCH;
        end
        S_FETCH: if (loc_ack) begin
          if (s_cur_hi) s_data[31:16] <= loc_rdata;
          else          s_data[15:0]  <= loc_rdata;
          if (!s_cur_hi && s_need_hi) s_cur_hi <= 1'b1;
          else begin st <= S_READY; age <= '0; end
        end
        S_READY: begin
          if (collect || expire) st <= S_IDLE;
          else                   age <= age + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req && !loc_ack |=> loc_req && $stable(loc_addr));

  // R2
  no_queue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && hst_req && dly && !wfifo_empty |=> st == S_IDLE && !loc_req);

  // R1
  first_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && hst_req && dly |=> hst_done && hst_term == T_RETRY);

  // R1
  collect_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_req && dly && hit && st == S_READY |=> st == S_IDLE && hst_term == T_DATA);

  // R3
  stat_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hst_req && in_stat && st == S_IDLE |=> st == S_IDLE && hst_term == T_DATA);

endmodule

// File: tb/test_drr_ctrl.sv
module test_drr_ctrl;
  localparam int AW = 16;
  localparam int LIM = 12;
  localparam logic [3:0] RD = 4'h6;

  logic clk = 0, rst_n = 0;
  logic hst_req = 0, hst_region = 0, wfifo_empty = 1;
  logic [AW-1:0] hst_addr = '0;
  logic [3:0] hst_cmd = '0, hst_be = '0;
  logic hst_done, loc_req, loc_reg_sel;
  logic [1:0] hst_term;
  logic [31:0] hst_rdata;
  logic [AW-2:0] loc_addr;
  logic loc_ack = 0;
  logic [15:0] loc_rdata = '0;

  drr_ctrl #(.ADDR_W(AW), .DISCARD_LIMIT(LIM)) i_drr_ctrl (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_region(hst_region),
    .hst_addr(hst_addr), .hst_cmd(hst_cmd), .hst_be(hst_be), .wfifo_empty(wfifo_empty),
    .hst_done(hst_done), .hst_term(hst_term), .hst_rdata(hst_rdata),
    .loc_req(loc_req), .loc_reg_sel(loc_reg_sel), .loc_addr(loc_addr),
    .loc_ack(loc_ack), .loc_rdata(loc_rdata));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int acks = 0, viol = 0, wait_states = 2, wcnt = 0;
  logic [AW-2:0] held = '0;
  logic [AW-2:0] alog [0:7];
  logic slog [0:7];
  logic r_done;
  logic [1:0] r_term;
  logic [31:0] r_data;

  function automatic logic [15:0] mdl(input logic sel, input logic [AW-2:0] a);
    return sel ? {8'hC3, a[7:0]} : (16'(a) ^ 16'h5A5A);
  endfunction

  function automatic logic [15:0] memw(input logic [AW-1:0] a, input logic h);
    return mdl(1'b0, {a[AW-1:2], h});
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (loc_ack) begin
        loc_ack = 0; wcnt = 0;
      end else if (loc_req) begin
        if (wcnt > 0 && loc_addr != held) viol++;
        held = loc_addr;
        if (wcnt >= wait_states) begin
          loc_ack = 1;
          loc_rdata = mdl(loc_reg_sel, loc_addr);
          alog[acks % 8] = loc_addr;
          slog[acks % 8] = loc_reg_sel;
          acks++;
        end else wcnt++;
      end else wcnt = 0;
    end
  end

  task automatic attempt(input logic rg, input logic [AW-1:0] a, input logic [3:0] c, input logic [3:0] b);
    hst_req = 1; hst_region = rg; hst_addr = a; hst_cmd = c; hst_be = b;
    @(negedge clk);
    r_done = hst_done; r_term = hst_term; r_data = hst_rdata;
    hst_req = 0;
  endtask

  task automatic poll_ready;
    for (int i = 0; i < 300; i++) begin
      attempt(1'b1, 16'h0800, RD, 4'hF);
      if (r_data[1]) break;
    end
  endtask

  task automatic drain(input logic rg, input logic [AW-1:0] a, input logic [3:0] b);
    poll_ready();
    attempt(rg, a, RD, b);
  endtask

  task automatic t_reset;
    check("R11 reset done", {31'b0, hst_done}, 0);
    check("R10 reset loc_req", {31'b0, loc_req}, 0);
    attempt(1'b1, 16'h0800, RD, 4'hF);
    check("R3 status after reset term", r_term, 2);
    check("R3 status after reset data", r_data, 0);
    attempt(1'b1, 16'h0804, RD, 4'hF);
    check("R3 other status reg", r_data, 0);
  endtask

  task automatic t_basic;
    int a0;
    wait_states = 4; a0 = acks;
    attempt(1'b0, 16'h0040, RD, 4'hF);
    check("R11 first attempt done", {31'b0, r_done}, 1);
    check("R1 first attempt retry", r_term, 1);
    attempt(1'b0, 16'h0040, RD, 4'hF);
    check("R1 repeat while fetching retry", r_term, 1);
    attempt(1'b1, 16'h0800, RD, 4'hF);
    check("R3 status during fetch", r_data, 32'h1);
    drain(1'b0, 16'h0040, 4'hF);
    check("R1 collect term", r_term, 2);
    check("R5 dword data", r_data, {memw(16'h0040, 1), memw(16'h0040, 0)});
    check("R5 two accesses", acks - a0, 2);
    check("R5 low half first", 32'(alog[a0 % 8]), 32'(16'h0020));
    check("R5 high half second", 32'(alog[(a0 + 1) % 8]), 32'(16'h0021));
    attempt(1'b0, 16'h0040, RD, 4'hF);
    check("R1 slot freed, new retry", r_term, 1);
    drain(1'b0, 16'h0040, 4'hF);
    check("R1 second collect", r_term, 2);
  endtask

  task automatic t_fifo;
    int a0;
    a0 = acks; wfifo_empty = 0;
    attempt(1'b0, 16'h0080, RD, 4'hF);
    check("R2 fifo busy retry", r_term, 1);
    repeat (10) @(negedge clk);
    check("R2 no local access", acks - a0, 0);
    attempt(1'b1, 16'h0800, RD, 4'hF);
    check("R2 R3 slot idle, fifo flag", r_data, 32'h4000_0000);
    wfifo_empty = 1;
    attempt(1'b0, 16'h0080, RD, 4'hF);
    check("R2 queued once empty", r_term, 1);
    drain(1'b0, 16'h0080, 4'hF);
    check("R2 collect data", r_data, {memw(16'h0080, 1), memw(16'h0080, 0)});
  endtask

  task automatic t_match;
    int a0;
    wait_states = 0;
    attempt(1'b0, 16'h0100, RD, 4'hF);
    poll_ready();
    attempt(1'b0, 16'h0100, RD, 4'h3);
    check("R4 be mismatch retry", r_term, 1);
    attempt(1'b0, 16'h0100, 4'hC, 4'hF);
    check("R4 cmd mismatch retry", r_term, 1);
    attempt(1'b0, 16'h0104, RD, 4'hF);
    check("R4 addr mismatch retry", r_term, 1);
    attempt(1'b1, 16'h0800, RD, 4'hF);
    check("R4 slot undisturbed", r_data, 32'h3);
    attempt(1'b0, 16'h0100, RD, 4'hF);
    check("R4 original collects", r_data, {memw(16'h0100, 1), memw(16'h0100, 0)});
    a0 = acks;
    attempt(1'b0, 16'h0100, RD, 4'h3);
    drain(1'b0, 16'h0100, 4'h3);
    check("R5 low half only", r_data, {16'h0, memw(16'h0100, 0)});
    check("R5 one access", acks - a0, 1);
    a0 = acks;
    attempt(1'b0, 16'h0200, RD, 4'h4);
    drain(1'b0, 16'h0200, 4'h4);
    check("R5 single byte gives whole upper word", r_data, {memw(16'h0200, 1), 16'h0});
    check("R5 upper word address", 32'(alog[a0 % 8]), 32'(16'h0101));
  endtask

  task automatic t_reg;
    int a0;
    attempt(1'b1, 16'h0010, RD, 4'h1);
    check("R6 one lower byte abort", r_term, 3);
    attempt(1'b1, 16'h0010, RD, 4'hB);
    check("R6 one upper byte abort", r_term, 3);
    attempt(1'b1, 16'h0400, RD, 4'hF);
    check("R6 unmapped abort", r_term, 3);
    a0 = acks; wfifo_empty = 0;
    attempt(1'b1, 16'h0010, RD, 4'hC);
    check("R7 upper-only reg zero term", r_term, 2);
    check("R7 upper-only reg zero data", r_data, 0);
    attempt(1'b0, 16'h0300, RD, 4'h0);
    check("R7 no enables zero term", r_term, 2);
    check("R7 no enables zero data", r_data, 0);
    repeat (4) @(negedge clk);
    check("R7 no local access", acks - a0, 0);
    wfifo_empty = 1; wait_states = 3; a0 = acks;
    attempt(1'b1, 16'h000C, RD, 4'hF);
    check("R8 reg read first retry", r_term, 1);
    drain(1'b1, 16'h000C, 4'hF);
    check("R8 reg data", r_data, {16'h0, 8'hC3, 8'h03});
    check("R8 one access", acks - a0, 1);
    check("R8 reg select", {31'b0, slog[a0 % 8]}, 1);
    check("R8 reg address", 32'(alog[a0 % 8]), 3);
  endtask

  task automatic t_discard;
    wait_states = 1;
    attempt(1'b0, 16'h0500, RD, 4'hF);
    poll_ready();
    repeat (LIM - 2) @(negedge clk);
    attempt(1'b0, 16'h0500, RD, 4'hF);
    check("R9 collect on expiry clock", r_term, 2);
    check("R9 collect data", r_data, {memw(16'h0500, 1), memw(16'h0500, 0)});
    attempt(1'b0, 16'h0500, RD, 4'hF);
    poll_ready();
    repeat (LIM - 1) @(negedge clk);
    attempt(1'b0, 16'h0500, RD, 4'hF);
    check("R9 discarded, retried", r_term, 1);
    drain(1'b0, 16'h0500, 4'hF);
    check("R9 requeued collects", r_term, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fifo();
    t_match();
    t_reg();
    t_discard();
    check("R10 address stable during waits", viol, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    summary();
    $finish;
  end
endmodule